// File: doc/BRIEF.md
# Lock Status Heartbeat Pulser

This block drives a status indicator LED with short, periodic, fixed-width pulses. The repetition rate shows whether the serial link is locked. Out of lock, the pulses come often. Once the link is locked, they come sixteen times less often. The LED is lit only a small fraction of the time, so its average drive current stays low.

A rate-select input chooses between standard and double timing. In double timing the block behaves as if its clock ran at half speed, so both the pulse width and the period double. A change of lock state outside a pulse starts a fresh pulse at once, so the new rate shows without waiting out a long locked period. The block uses counters only and assumes a fixed nominal system clock. Lock detection and LED current limiting happen elsewhere.

Top module: `lock_hb_pulser`

## Requirements
- R1: While reset is asserted, `led_o` is 1. The first pulse starts at reset release and lasts exactly PULSE_W cycles (default 73,728) in standard timing.
- R2: With `lock_i` = 0 and `dbl_i` = 0, `led_o` repeats every UNLOCK_PERIOD cycles (default 1,152,000). It is 1 for PULSE_W cycles and 0 for the rest of each period. The output is active high.
- R3: With `lock_i` = 1 and `dbl_i` = 0, the period is LOCK_RATIO × UNLOCK_PERIOD cycles (default 16 × 1,152,000). The pulse width is still PULSE_W.
- R4: With `dbl_i` = 1, every duration doubles: the pulse lasts 2 × PULSE_W cycles and the period is twice the standard period for the current lock state.
- R5: A change of `lock_i` seen at a clock edge while `led_o` is 0 starts a new pulse at that edge. The new pulse has full width and is followed by the period of the new lock state, counted from that edge, in either timing mode.
- R6: A change of `lock_i` while `led_o` is 1 does not shorten or lengthen that pulse. The next pulse starts one new-state period after the start of the current pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Link locked flag, 1 = locked |
| dbl_i | input | 1 | Timing select, 0 = standard, 1 = double (held static while running) |
| led_o | output | 1 | Active-high LED drive |

## Verification
A corrupted period counter shows up as a pulse that is too long or too short, or as a gap between pulses that does not match the lock state. A width error appears by the falling edge of the pulse in progress. A period error appears by the next rising edge. A stale lock register shows within one cycle when a change outside a pulse fails to relight the LED. A prescaler phase that is not cleared on restart shows as a restarted double-timing pulse that runs one cycle short.

// File: rtl/hb_pkg.sv
package hb_pkg;
  function automatic int unsigned hb_cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef struct packed {
    logic tick;
    logic restart;
  } hb_ctl_t;
endpackage

// File: rtl/hb_tick_gen.sv
module hb_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbl_i,
  input  logic restart_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= 1'b0;
    else if (restart_i) phase_q <= 1'b0;
    else if (dbl_i)     phase_q <= ~phase_q;
    else                phase_q <= 1'b0;
  end

  // double timing: one tick per two clocks, aligned to restart
  assign tick_o = ~dbl_i | phase_q;
endmodule

// File: rtl/hb_lock_watch.sv
module hb_lock_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic in_pulse_i,
  output logic lock_q_o,
  output logic restart_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_i;
  end

  assign lock_q_o  = lock_q;
  // changes inside a pulse only retarget the period
  assign restart_o = (lock_i != lock_q) && !in_pulse_i;
endmodule

// File: rtl/hb_phase_cnt.sv
module hb_phase_cnt #(
  parameter int unsigned PULSE_W       = 73728,
  parameter int unsigned UNLOCK_PERIOD = 1152000,
  parameter int unsigned LOCK_RATIO    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  hb_pkg::hb_ctl_t ctl_i,
  input  logic locked_i,
  output logic in_pulse_o
);
  localparam int unsigned LOCK_PERIOD = UNLOCK_PERIOD * LOCK_RATIO;
  localparam int unsigned CNT_W       = hb_pkg::hb_cnt_w(LOCK_PERIOD);
  localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(PULSE_W);
  localparam logic [CNT_W-1:0] ULAST_C = CNT_W'(UNLOCK_PERIOD - 1);
  localparam logic [CNT_W-1:0] LLAST_C = CNT_W'(LOCK_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = locked_i ? LLAST_C : ULAST_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (ctl_i.restart)    cnt_q <= '0;
    else if (ctl_i.tick) begin
      if (cnt_q >= last)       cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_pulse_o = (cnt_q < WIDTH_C);
endmodule

// File: rtl/lock_hb_pulser.sv
module lock_hb_pulser #(
  parameter int unsigned PULSE_W       = 73728,
  parameter int unsigned UNLOCK_PERIOD = 1152000,
  parameter int unsigned LOCK_RATIO    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic dbl_i,
  output logic led_o
);
  hb_pkg::hb_ctl_t ctl;
  logic locked_q;
  logic in_pulse;

  hb_lock_watch i_watch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (lock_i),
    .in_pulse_i (in_pulse),
    .lock_q_o   (locked_q),
    .restart_o  (ctl.restart)
  );

  hb_tick_gen i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dbl_i     (dbl_i),
    .restart_i (ctl.restart),
    .tick_o    (ctl.tick)
  );

  hb_phase_cnt #(
    .PULSE_W       (PULSE_W),
    .UNLOCK_PERIOD (UNLOCK_PERIOD),
    .LOCK_RATIO    (LOCK_RATIO)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl),
    .locked_i   (locked_q),
    .in_pulse_o (in_pulse)
  );

  assign led_o = in_pulse;
endmodule

// File: rtl/hb_pulser_chk.sv
module hb_pulser_chk #(
  parameter int unsigned PULSE_W       = 73728,
  parameter int unsigned UNLOCK_PERIOD = 1152000,
  parameter int unsigned LOCK_RATIO    = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_i,
  input logic dbl_i,
  input logic led_o
);
  localparam logic [31:0] LOCK_PERIOD = 32'(UNLOCK_PERIOD * LOCK_RATIO);

  logic [31:0] hi_run, lo_run;
  logic        lk_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= '0;
      lk_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hi_run <= led_o ? hi_run + 1 : '0;
      lo_run <= led_o ? '0 : lo_run + 1;
      lk_q   <= lock_i;
      seen_q <= 1'b1;
    end
  end

  // R1
  first_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> led_o);

  // R4 R6 (width also covers R1)
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(led_o)) |-> (hi_run == (dbl_i ? 32'(2*PULSE_W) : 32'(PULSE_W))));

  // R3
  gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !led_o |-> (lo_run < 2*LOCK_PERIOD));

  // R5
  relock_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (lock_i != lk_q) && !led_o) |=> led_o);
endmodule

bind lock_hb_pulser hb_pulser_chk #(
  .PULSE_W       (PULSE_W),
  .UNLOCK_PERIOD (UNLOCK_PERIOD),
  .LOCK_RATIO    (LOCK_RATIO)
) i_hb_pulser_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .lock_i (lock_i),
  .dbl_i  (dbl_i),
  .led_o  (led_o)
);

// File: tb/test_lock_hb_pulser.sv
module test_lock_hb_pulser;
  localparam int W = 4;
  localparam int P = 20;
  localparam int RATIO = 16;
  localparam int LP = P * RATIO;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lock_i = 1'b0;
  logic dbl_i = 1'b0;
  logic led_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  lock_hb_pulser #(
    .PULSE_W       (W),
    .UNLOCK_PERIOD (P),
    .LOCK_RATIO    (RATIO)
  ) i_lock_hb_pulser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock_i),
    .dbl_i  (dbl_i),
    .led_o  (led_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit lk, bit dbl);
    @(negedge clk_i);
    rst_ni = 1'b0;
    lock_i = lk;
    dbl_i  = dbl;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // from a negedge inside a pulse: count high samples, then low samples
  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (led_o === 1'b1 && hi < 100000) begin hi++; @(negedge clk_i); end
    while (led_o === 1'b0 && lo < 100000) begin lo++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    int h, l;
    @(negedge clk_i);
    rst_ni = 1'b0;
    lock_i = 1'b0;
    dbl_i  = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 led during reset", int'(led_o), 1);
    rst_ni = 1'b1;
    measure(h, l);
    chk("R1 first pulse width", h, W);
  endtask

  task automatic t_unlocked();
    int h, l;
    do_reset(1'b0, 1'b0);
    measure(h, l);
    chk("R2 width", h, W);
    chk("R2 gap", l, P - W);
    measure(h, l);
    chk("R2 width second", h, W);
    chk("R2 gap second", l, P - W);
  endtask

  task automatic t_locked();
    int h, l;
    do_reset(1'b1, 1'b0);
    measure(h, l);
    chk("R3 width", h, W);
    chk("R3 gap", l, LP - W);
    measure(h, l);
    chk("R3 gap second", l, LP - W);
  endtask

  task automatic t_double();
    int h, l;
    do_reset(1'b0, 1'b1);
    measure(h, l);
    chk("R4 unlocked width", h, 2 * W);
    chk("R4 unlocked gap", l, 2 * (P - W));
    do_reset(1'b1, 1'b1);
    measure(h, l);
    chk("R4 locked width", h, 2 * W);
    chk("R4 locked gap", l, 2 * (LP - W));
  endtask

  task automatic t_change_low();
    int h, l;
    do_reset(1'b0, 1'b0);
    repeat (W + 3) @(negedge clk_i);
    chk("R5 low before change", int'(led_o), 0);
    lock_i = 1'b1;
    @(negedge clk_i);
    chk("R5 relit after lock", int'(led_o), 1);
    measure(h, l);
    chk("R5 width after lock", h, W);
    chk("R5 gap after lock", l, LP - W);
    repeat (50) @(negedge clk_i);
    chk("R5 low before unlock", int'(led_o), 0);
    lock_i = 1'b0;
    @(negedge clk_i);
    chk("R5 relit after unlock", int'(led_o), 1);
    measure(h, l);
    chk("R5 width after unlock", h, W);
    chk("R5 gap after unlock", l, P - W);
    do_reset(1'b0, 1'b1);
    repeat (2 * W + 5) @(negedge clk_i);
    lock_i = 1'b1;
    @(negedge clk_i);
    measure(h, l);
    chk("R5 double width after lock", h, 2 * W);
    chk("R5 double gap after lock", l, 2 * (LP - W));
  endtask

  task automatic t_change_high();
    int h, l;
    do_reset(1'b0, 1'b0);
    repeat (2) @(negedge clk_i);
    lock_i = 1'b1;
    measure(h, l);
    chk("R6 rest of pulse on lock", h, W - 2);
    chk("R6 gap on lock", l, LP - W);
    repeat (1) @(negedge clk_i);
    lock_i = 1'b0;
    measure(h, l);
    chk("R6 rest of pulse on unlock", h, W - 1);
    chk("R6 gap on unlock", l, P - W);
  endtask

  initial begin
    t_reset();
    t_unlocked();
    t_locked();
    t_double();
    t_change_low();
    t_change_high();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule